// File: doc/BRIEF.md
# Sliding-Window Block Score Accumulator

This block scores every detection window of a linear classifier that runs over a grid of feature blocks. Blocks arrive one at a time in raster order. Each block carries `FEATS` signed fixed-point features. The block finds every window of `WIN_W` by `WIN_H` blocks that contains the incoming block. For each such window it forms the dot product of the block with the slice of the weight vector that matches the block's offset inside that window. It then adds that dot product to the window's running sum.

Running sums are kept in a small ring of words, one word for each window column and each window row modulo `RING_ROWS`. Each word holds a signed partial sum and a count of the blocks added so far. When the count reaches `WIN_W*WIN_H`, the block adds a fixed bias and releases the score with the window's coordinates. The word is then free for a window further down the grid.

The block takes the next input block only after it has visited all windows of the current one. With the default sizes, a grid of 79 by 59 blocks gives 73 by 45 windows.

Top module: `hogcls_window_acc`

## Requirements
- R1: After a synchronous active-low reset, `blk_ready` is 1 and `score_valid` is 0.
- R2: A block is taken on a clock edge where `blk_valid` and `blk_ready` are both 1. After that edge, `blk_ready` stays 0 for exactly N cycles and then returns to 1. N is the number of windows that contain the block: (min(bx,NWX-1) - max(0,bx-WIN_W+1) + 1) * (min(by,NWY-1) - max(0,by-WIN_H+1) + 1), where NWX = GRID_W-WIN_W+1 and NWY = GRID_H-WIN_H+1.
- R3: Accepted blocks take grid positions (bx,by) in raster order, with bx varying fastest. After position (GRID_W-1, GRID_H-1), the next block goes back to (0,0) and starts a new frame.
- R4: The weight for feature e of a block at offset (ox,oy) inside a window is word a = (oy*WIN_W+ox)*FEATS + e of a weight store. Word a holds ((29*a+7) mod 997) - 498 as a signed 10-bit value with 8 fractional bits. Feature e occupies bits [e*FEAT_W +: FEAT_W] of `blk_feats`, signed, with 8 fractional bits.
- R5: Each feature is multiplied by its weight. Each product is shifted arithmetically right by 8, which rounds toward minus infinity. The shifted products of a block are summed to form the block's dot product.
- R6: A window's running sum is kept modulo 2^PSUM_W as a signed value. It restarts from zero at the window's top-left block, offset (0,0).
- R7: Each window produces exactly one score per frame. The score appears after the window's WIN_W*WIN_H-th contribution. It equals the running sum, sign-extended to PSUM_W+1 bits, plus BIAS. `score_wx` and `score_wy` carry the window's column and row.
- R8: Within one block, windows are visited with the row ascending in the outer loop and the column ascending in the inner loop. Scores leave in the order their windows complete.
- R9: Windows in rows wy and wy+RING_ROWS share storage, and RING_ROWS >= WIN_H is assumed. Scores stay correct in later window rows and in later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_valid | input | 1 | Input block present |
| blk_ready | output | 1 | Block can be taken this cycle |
| blk_feats | input | FEATS*FEAT_W | Packed signed block features |
| score_valid | output | 1 | Window score present (one cycle) |
| score | output | PSUM_W+1 | Signed score with bias |
| score_wx | output | clog2(NWX) | Window column |
| score_wy | output | clog2(NWY) | Window row |

## Verification
The bench runs three frames on a reduced grid, and the ring depth equals the window height so that every storage word is reused. The first frame uses uniform features, which exposes errors in the counting and completion logic. The second frame has a single non-zero block. That frame separates windows that contain the block from windows that must score only the bias, so a wrong window range or offset shows up directly. The third frame uses pseudo-random signed features, which catches weight-address, rounding and wrap errors and checks that words left over from the previous frames are restarted. For every block, the number of cycles that `blk_ready` stays low is compared with the expected number of covering windows.

// File: rtl/hogcls_pkg.sv
// Shared definitions for the sliding-window score accumulator.
// Holds the sequencer state type and the constants of the computed weight store.
package hogcls_pkg;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_t;

    // Weight word a holds ((WGT_MUL*a + WGT_ADD) mod WGT_MOD) - WGT_OFF
    localparam int WGT_MUL = 29;
    localparam int WGT_ADD = 7;
    localparam int WGT_MOD = 997;
    localparam int WGT_OFF = 498;

endpackage

// File: rtl/hogcls_weight_rom.sv
// Weight store: gives all FEATS weights for one block offset (ox,oy) at once.
// Assumes W_W >= 10, so that every stored value fits. The contents are computed, not loaded.
module hogcls_weight_rom
    import hogcls_pkg::*;
#(
    parameter int FEATS = 36,
    parameter int WIN_W = 7,
    parameter int WIN_H = 15,
    parameter int W_W   = 10,
    localparam int OX_W = $clog2(WIN_W > 1 ? WIN_W : 2),
    localparam int OY_W = $clog2(WIN_H > 1 ? WIN_H : 2)
)(
    input  logic [OX_W-1:0]      ox,
    input  logic [OY_W-1:0]      oy,
    output logic [FEATS*W_W-1:0] wts
);

    int base;
    int addr;
    int val;

    // Look up the weight slice that starts at word (oy*WIN_W+ox)*FEATS
    always_comb begin
        base = (int'(oy) * WIN_W + int'(ox)) * FEATS;
        wts  = '0;
        addr = 0;
        val  = 0;
        for (int e = 0; e < FEATS; e++) begin
            addr = base + e;
            val  = ((addr * WGT_MUL + WGT_ADD) % WGT_MOD) - WGT_OFF;
            wts[e*W_W +: W_W] = W_W'(val);
        end
    end

endmodule

// File: rtl/hogcls_dot.sv
// Parallel multiply and sum: multiplies FEATS features by FEATS weights in one
// cycle, keeps FRAC fractional bits of each product (arithmetic shift) and
// adds them all. Purely combinational. The caller registers the result.
module hogcls_dot #(
    parameter int FEATS  = 36,
    parameter int FEAT_W = 10,
    parameter int W_W    = 10,
    parameter int FRAC   = 8,
    localparam int PROD_W = FEAT_W + W_W - FRAC,
    localparam int DOT_W  = PROD_W + $clog2(FEATS > 1 ? FEATS : 2)
)(
    input  logic [FEATS*FEAT_W-1:0]  feats,
    input  logic [FEATS*W_W-1:0]     wts,
    output logic signed [DOT_W-1:0]  dot
);

    logic signed [PROD_W-1:0] prod_sh [FEATS];

    for (genvar e = 0; e < FEATS; e++) begin : g_mul
        logic signed [FEAT_W-1:0]     f;
        logic signed [W_W-1:0]        w;
        logic signed [FEAT_W+W_W-1:0] p;
        logic signed [FEAT_W+W_W-1:0] p_sh;
        assign f       = feats[e*FEAT_W +: FEAT_W];
        assign w       = wts[e*W_W +: W_W];
        assign p       = f * w;
        assign p_sh    = p >>> FRAC;
        assign prod_sh[e] = p_sh[PROD_W-1:0];
    end

    // Sum the scaled products with sign extension
    always_comb begin
        dot = '0;
        for (int e = 0; e < FEATS; e++) begin
            dot = dot + DOT_W'(prod_sh[e]);
        end
    end

endmodule

// File: rtl/hogcls_seq.sv
// Block sequencer: takes one block in raster order and walks every window
// that contains it (row outer, column inner), one window per cycle.
// blk_ready is high only when no block is being walked.
// Assumes GRID_W >= WIN_W and GRID_H >= WIN_H.
module hogcls_seq
    import hogcls_pkg::*;
#(
    parameter int GRID_W = 79,
    parameter int GRID_H = 59,
    parameter int WIN_W  = 7,
    parameter int WIN_H  = 15,
    parameter int DATA_W = 360,
    localparam int NWX  = GRID_W - WIN_W + 1,
    localparam int NWY  = GRID_H - WIN_H + 1,
    localparam int BX_W = $clog2(GRID_W > 1 ? GRID_W : 2),
    localparam int BY_W = $clog2(GRID_H > 1 ? GRID_H : 2),
    localparam int WX_W = $clog2(NWX > 1 ? NWX : 2),
    localparam int WY_W = $clog2(NWY > 1 ? NWY : 2),
    localparam int OX_W = $clog2(WIN_W > 1 ? WIN_W : 2),
    localparam int OY_W = $clog2(WIN_H > 1 ? WIN_H : 2)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    output logic              blk_ready,
    input  logic [DATA_W-1:0] blk_data,
    output logic [DATA_W-1:0] data_q,
    output logic              iss_valid,
    output logic [WX_W-1:0]   iss_wx,
    output logic [WY_W-1:0]   iss_wy,
    output logic [OX_W-1:0]   iss_ox,
    output logic [OY_W-1:0]   iss_oy
);

    sq_state_t       state;
    logic [BX_W-1:0] pos_x, bx_q;
    logic [BY_W-1:0] pos_y, by_q;
    logic [WX_W-1:0] wx_lo_c, wx_hi_c, wx_lo_q, wx_hi_q, it_wx;
    logic [WY_W-1:0] wy_lo_c, wy_hi_c, wy_hi_q, it_wy;
    logic [BX_W-1:0] dx;
    logic [BY_W-1:0] dy;
    int px, py;

    // Range of windows that contain the block at the next raster position
    always_comb begin
        px      = int'(pos_x);
        py      = int'(pos_y);
        wx_lo_c = WX_W'((px >= WIN_W - 1) ? px - (WIN_W - 1) : 0);
        wx_hi_c = WX_W'((px < NWX) ? px : NWX - 1);
        wy_lo_c = WY_W'((py >= WIN_H - 1) ? py - (WIN_H - 1) : 0);
        wy_hi_c = WY_W'((py < NWY) ? py : NWY - 1);
    end

    // Take a block, walk its windows, and advance the raster position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            pos_x   <= '0;
            pos_y   <= '0;
            bx_q    <= '0;
            by_q    <= '0;
            wx_lo_q <= '0;
            wx_hi_q <= '0;
            wy_hi_q <= '0;
            it_wx   <= '0;
            it_wy   <= '0;
            data_q  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (blk_valid) begin
                        data_q  <= blk_data;
                        bx_q    <= pos_x;
                        by_q    <= pos_y;
                        wx_lo_q <= wx_lo_c;
                        wx_hi_q <= wx_hi_c;
                        wy_hi_q <= wy_hi_c;
                        it_wx   <= wx_lo_c;
                        it_wy   <= wy_lo_c;
                        state   <= SQ_RUN;
                        if (pos_x == BX_W'(GRID_W - 1)) begin
                            pos_x <= '0;
                            pos_y <= (pos_y == BY_W'(GRID_H - 1)) ? '0 : pos_y + 1'b1;
                        end else begin
                            pos_x <= pos_x + 1'b1;
                        end
                    end
                end
                SQ_RUN: begin
                    if (it_wx == wx_hi_q) begin
                        it_wx <= wx_lo_q;
                        if (it_wy == wy_hi_q) begin
                            state <= SQ_IDLE;
                        end else begin
                            it_wy <= it_wy + 1'b1;
                        end
                    end else begin
                        it_wx <= it_wx + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Offset of the held block inside the window being visited
    always_comb begin
        dx = bx_q - BX_W'(it_wx);
        dy = by_q - BY_W'(it_wy);
    end

    assign blk_ready = (state == SQ_IDLE);
    assign iss_valid = (state == SQ_RUN);
    assign iss_wx    = it_wx;
    assign iss_wy    = it_wy;
    assign iss_ox    = OX_W'(dx);
    assign iss_oy    = OY_W'(dy);

    // R2: a taken block holds off the next one for at least a cycle
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid && blk_ready |=> !blk_ready);

    // R4: the visited window really contains the held block
    p_offset_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (int'(dx) < WIN_W) && (int'(dy) < WIN_H));

    // R3: raster position stays inside the grid
    p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pos_x) < GRID_W) && (int'(pos_y) < GRID_H));

endmodule

// File: rtl/hogcls_psum_ram.sv
// Partial-sum ring: one word of {count, sum} for each window column and each
// window row modulo RING_ROWS. Each valid contribution does a read-modify-write
// in one cycle. The first contribution of a window restarts its word. When the
// count reaches WIN_W*WIN_H, the biased score is registered out.
// Assumes RING_ROWS >= WIN_H and contributions in raster block order.
module hogcls_psum_ram #(
    parameter int NWX       = 73,
    parameter int NWY       = 45,
    parameter int RING_ROWS = 30,
    parameter int WIN_W     = 7,
    parameter int WIN_H     = 15,
    parameter int PSUM_W    = 12,
    parameter int DOT_W     = 18,
    parameter int BIAS      = 16,
    localparam int WX_W    = $clog2(NWX > 1 ? NWX : 2),
    localparam int WY_W    = $clog2(NWY > 1 ? NWY : 2),
    localparam int FULL    = WIN_W * WIN_H,
    localparam int CNT_W   = $clog2(FULL + 1),
    localparam int DEPTH   = RING_ROWS * NWX,
    localparam int AD_W    = $clog2(DEPTH > 1 ? DEPTH : 2),
    localparam int WORD_W  = CNT_W + PSUM_W,
    localparam int SCORE_W = PSUM_W + 1
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [WX_W-1:0]           in_wx,
    input  logic [WY_W-1:0]           in_wy,
    input  logic                      in_first,
    input  logic signed [DOT_W-1:0]   in_dot,
    output logic                      score_valid,
    output logic signed [SCORE_W-1:0] score,
    output logic [WX_W-1:0]           score_wx,
    output logic [WY_W-1:0]           score_wy
);

    logic [WORD_W-1:0]        mem [DEPTH];
    logic                     a_valid, a_first;
    logic [WX_W-1:0]          a_wx;
    logic [WY_W-1:0]          a_wy;
    logic [AD_W-1:0]          a_addr;
    logic signed [DOT_W-1:0]  a_dot;
    logic [WORD_W-1:0]        rd_word;
    logic [CNT_W-1:0]         rd_cnt, new_cnt;
    logic signed [PSUM_W-1:0] rd_psum, new_psum;
    logic                     win_done;
    int                       ring_addr;

    // Ring address: row slot times columns plus column
    always_comb begin
        ring_addr = (int'(in_wy) % RING_ROWS) * NWX + int'(in_wx);
    end

    // Stage A: register the contribution and its ring address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_first <= 1'b0;
            a_wx    <= '0;
            a_wy    <= '0;
            a_addr  <= '0;
            a_dot   <= '0;
        end else begin
            a_valid <= in_valid;
            a_first <= in_first;
            a_wx    <= in_wx;
            a_wy    <= in_wy;
            a_addr  <= AD_W'(ring_addr);
            a_dot   <= in_dot;
        end
    end

    // Read the addressed word and form the updated sum and count
    always_comb begin
        rd_word  = mem[a_addr];
        rd_cnt   = rd_word[WORD_W-1:PSUM_W];
        rd_psum  = rd_word[PSUM_W-1:0];
        new_psum = (a_first ? '0 : rd_psum) + a_dot[PSUM_W-1:0];
        new_cnt  = (a_first ? '0 : rd_cnt) + 1'b1;
        win_done = a_valid && (new_cnt == CNT_W'(FULL));
    end

    // Write back the updated word
    always_ff @(posedge clk) begin
        if (a_valid) begin
            mem[a_addr] <= {new_cnt, new_psum};
        end
    end

    // Stage B: register the biased score of a completed window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score_valid <= 1'b0;
            score       <= '0;
            score_wx    <= '0;
            score_wy    <= '0;
        end else begin
            score_valid <= win_done;
            if (win_done) begin
                score    <= SCORE_W'(new_psum) + SCORE_W'(BIAS);
                score_wx <= a_wx;
                score_wy <= a_wy;
            end
        end
    end

    // R6: a non-first contribution always finds a live, unfinished word
    p_live_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid && !a_first |-> (rd_cnt != '0) && (int'(rd_cnt) < FULL));

    // R7: a released score carries coordinates of a real window
    p_score_coord_r7: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |-> (int'(score_wx) < NWX) && (int'(score_wy) < NWY));

    // R9: a restarted word is addressed by a window's first block only
    p_first_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> !a_first || (FULL == 1));

endmodule

// File: rtl/hogcls_window_acc.sv
// Top of the sliding-window block score accumulator. A block stream enters in
// raster order over a GRID_W x GRID_H grid. Each block's dot product with the
// weight slice for its offset is added into every WIN_W x WIN_H window that
// contains it. Biased scores leave with window coordinates.
// Assumes RING_ROWS >= WIN_H, W_W >= 10, and BIAS fits in PSUM_W signed bits.
module hogcls_window_acc #(
    parameter int GRID_W    = 79,
    parameter int GRID_H    = 59,
    parameter int WIN_W     = 7,
    parameter int WIN_H     = 15,
    parameter int RING_ROWS = 30,
    parameter int FEATS     = 36,
    parameter int FEAT_W    = 10,
    parameter int W_W       = 10,
    parameter int FRAC      = 8,
    parameter int PSUM_W    = 12,
    parameter int BIAS      = 16,
    localparam int NWX    = GRID_W - WIN_W + 1,
    localparam int NWY    = GRID_H - WIN_H + 1,
    localparam int WX_W   = $clog2(NWX > 1 ? NWX : 2),
    localparam int WY_W   = $clog2(NWY > 1 ? NWY : 2),
    localparam int DATA_W = FEATS * FEAT_W
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     blk_valid,
    output logic                     blk_ready,
    input  logic [DATA_W-1:0]        blk_feats,
    output logic                     score_valid,
    output logic signed [PSUM_W:0]   score,
    output logic [WX_W-1:0]          score_wx,
    output logic [WY_W-1:0]          score_wy
);

    localparam int OX_W  = $clog2(WIN_W > 1 ? WIN_W : 2);
    localparam int OY_W  = $clog2(WIN_H > 1 ? WIN_H : 2);
    localparam int DOT_W = FEAT_W + W_W - FRAC + $clog2(FEATS > 1 ? FEATS : 2);

    logic [DATA_W-1:0]       data_q;
    logic                    iss_valid;
    logic [WX_W-1:0]         iss_wx;
    logic [WY_W-1:0]         iss_wy;
    logic [OX_W-1:0]         iss_ox;
    logic [OY_W-1:0]         iss_oy;
    logic [FEATS*W_W-1:0]    wts;
    logic signed [DOT_W-1:0] dot;
    logic                    iss_first;

    hogcls_seq #(
        .GRID_W (GRID_W),
        .GRID_H (GRID_H),
        .WIN_W  (WIN_W),
        .WIN_H  (WIN_H),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_valid (blk_valid),
        .blk_ready (blk_ready),
        .blk_data  (blk_feats),
        .data_q    (data_q),
        .iss_valid (iss_valid),
        .iss_wx    (iss_wx),
        .iss_wy    (iss_wy),
        .iss_ox    (iss_ox),
        .iss_oy    (iss_oy)
    );

    hogcls_weight_rom #(
        .FEATS (FEATS),
        .WIN_W (WIN_W),
        .WIN_H (WIN_H),
        .W_W   (W_W)
    ) u_rom (
        .ox  (iss_ox),
        .oy  (iss_oy),
        .wts (wts)
    );

    hogcls_dot #(
        .FEATS  (FEATS),
        .FEAT_W (FEAT_W),
        .W_W    (W_W),
        .FRAC   (FRAC)
    ) u_dot (
        .feats (data_q),
        .wts   (wts),
        .dot   (dot)
    );

    // The top-left block of a window starts its running sum
    assign iss_first = (iss_ox == '0) && (iss_oy == '0);

    hogcls_psum_ram #(
        .NWX       (NWX),
        .NWY       (NWY),
        .RING_ROWS (RING_ROWS),
        .WIN_W     (WIN_W),
        .WIN_H     (WIN_H),
        .PSUM_W    (PSUM_W),
        .DOT_W     (DOT_W),
        .BIAS      (BIAS)
    ) u_ram (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (iss_valid),
        .in_wx       (iss_wx),
        .in_wy       (iss_wy),
        .in_first    (iss_first),
        .in_dot      (dot),
        .score_valid (score_valid),
        .score       (score),
        .score_wx    (score_wx),
        .score_wy    (score_wy)
    );

    // R1: no score leaves in the cycle right after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !score_valid);

endmodule

// File: tb/hogcls_window_acc_bench.sv
// Scoreboard bench on a reduced grid: a driver predicts scores from the
// requirements and queues them; a monitor compares them in arrival order.
module hogcls_window_acc_bench;

    localparam int GW = 6, GH = 5, WW = 3, WH = 2, RING = 2;
    localparam int FEATS = 36, FEAT_W = 10, PSUM_W = 12, BIAS = -37;
    localparam int NWX = GW - WW + 1, NWY = GH - WH + 1;
    localparam int WX_W = $clog2(NWX), WY_W = $clog2(NWY);
    localparam int FULL = WW * WH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blk_valid = 1'b0;
    logic blk_ready;
    logic [FEATS*FEAT_W-1:0] blk_feats = '0;
    logic score_valid;
    logic signed [PSUM_W:0] score;
    logic [WX_W-1:0] score_wx;
    logic [WY_W-1:0] score_wy;

    int checks = 0;
    int errors = 0;
    int frame_no = 0;
    bit done = 1'b0;

    int exp_s[$];
    int exp_x[$];
    int exp_y[$];
    int m_psum [NWX][NWY];
    int m_cnt  [NWX][NWY];

    always #10 clk = ~clk;

    hogcls_window_acc #(
        .GRID_W (GW), .GRID_H (GH), .WIN_W (WW), .WIN_H (WH),
        .RING_ROWS (RING), .FEATS (FEATS), .FEAT_W (FEAT_W),
        .W_W (10), .FRAC (8), .PSUM_W (PSUM_W), .BIAS (BIAS)
    ) u_hogcls_window_acc (
        .clk (clk), .rst_n (rst_n),
        .blk_valid (blk_valid), .blk_ready (blk_ready), .blk_feats (blk_feats),
        .score_valid (score_valid), .score (score),
        .score_wx (score_wx), .score_wy (score_wy)
    );

    // R4: weight word contents
    function automatic int wgt(int a);
        return ((29 * a + 7) % 997) - 498;
    endfunction

    // Signed wrap to PSUM_W bits (R6)
    function automatic int wrap(int v);
        int m;
        m = v & ((1 << PSUM_W) - 1);
        if (m >= (1 << (PSUM_W - 1))) m = m - (1 << PSUM_W);
        return m;
    endfunction

    function automatic int feat(int mode, int bidx, int e);
        if (mode == 0) return 256;
        if (mode == 1) return (bidx == 13) ? (e * 7 - 100) : 0;
        return ((bidx * 131 + e * 53 + 17 + frame_no * 71) % 511) - 255;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: predict the effect of one block, then send it and time ready
    task automatic send_block(int mode, int bidx, int gap);
        int bx, by, xlo, xhi, ylo, yhi, nwin, lowc, d, f;
        bx = bidx % GW;
        by = bidx / GW;
        xlo = (bx >= WW - 1) ? bx - (WW - 1) : 0;
        xhi = (bx < NWX) ? bx : NWX - 1;
        ylo = (by >= WH - 1) ? by - (WH - 1) : 0;
        yhi = (by < NWY) ? by : NWY - 1;
        nwin = (xhi - xlo + 1) * (yhi - ylo + 1);
        // R8: row ascending outer, column ascending inner
        for (int wy = ylo; wy <= yhi; wy++) begin
            for (int wx = xlo; wx <= xhi; wx++) begin
                d = 0;
                for (int e = 0; e < FEATS; e++) begin
                    f = feat(mode, bidx, e);
                    d = d + ((f * wgt(((by - wy) * WW + (bx - wx)) * FEATS + e)) >>> 8);
                end
                if (bx == wx && by == wy) begin
                    m_psum[wx][wy] = 0;
                    m_cnt[wx][wy] = 0;
                end
                m_psum[wx][wy] = wrap(m_psum[wx][wy] + d);
                m_cnt[wx][wy]++;
                if (m_cnt[wx][wy] == FULL) begin
                    exp_s.push_back(m_psum[wx][wy] + BIAS);
                    exp_x.push_back(wx);
                    exp_y.push_back(wy);
                end
            end
        end
        @(negedge clk);
        for (int e = 0; e < FEATS; e++) begin
            f = feat(mode, bidx, e);
            blk_feats[e*FEAT_W +: FEAT_W] = FEAT_W'(f);
        end
        blk_valid = 1'b1;
        while (!blk_ready) @(negedge clk);
        @(negedge clk);
        blk_valid = 1'b0;
        lowc = 0;
        while (!blk_ready) begin
            lowc++;
            @(negedge clk);
        end
        // R2: ready low for exactly the covering-window count
        check(lowc == nwin, "R2 ready-low cycles", lowc, nwin);
        repeat (gap) @(negedge clk);
    endtask

    // Monitor: compare every released score against the queue head
    always @(negedge clk) begin
        if (rst_n && score_valid) begin
            if (exp_s.size() == 0) begin
                check(1'b0, "R7 unexpected score", int'(score), 0);
            end else begin
                int es, ex, ey;
                es = exp_s.pop_front();
                ex = exp_x.pop_front();
                ey = exp_y.pop_front();
                if (frame_no > 0)
                    check(int'(score) == es, "R9 R5 R6 score after reuse", int'(score), es);
                else
                    check(int'(score) == es, "R5 R6 R7 score", int'(score), es);
                check(int'(score_wx) == ex, "R8 R3 window column", int'(score_wx), ex);
                check(int'(score_wy) == ey, "R8 R3 window row", int'(score_wy), ey);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(blk_ready == 1'b1, "R1 ready after reset", int'(blk_ready), 1);
        check(score_valid == 1'b0, "R1 score idle after reset", int'(score_valid), 0);
        for (int fr = 0; fr < 3; fr++) begin
            frame_no = fr;
            for (int b = 0; b < GW * GH; b++) begin
                send_block(fr, b, (b % 4 == 1) ? 2 : 0);
            end
        end
        repeat (10) @(negedge clk);
        // R7: every predicted score was seen exactly once
        check(exp_s.size() == 0, "R7 scores left unseen", exp_s.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule